// File: doc/BRIEF.md
# Protected Full-Bridge Control Core

This block is the digital heart of a protected full bridge. It turns two leg-direction inputs and a pair of opposite-sense inhibit inputs into a registered command for each leg: drive high, drive low, or release to high impedance. It also drives an active-low fault status output. The analog front end supplies protection flags as single-bit inputs: a hard short, an overtemperature trip, a supply undervoltage, and a "cool" flag meaning that the temperature is back below the trip point minus its hysteresis.

A short or an overtemperature trip latches both legs off. The latch ignores the direction inputs and holds after the flag goes away. The only way to clear it is to toggle an inhibit input: the active-high inhibit falling, or the active-low inhibit rising. An overtemperature latch clears only while the cool flag is set. Undervoltage releases the legs while it lasts and recovers without a toggle. Each pin also has a floating indication that stands in for its on-chip pull. The direction pins and the active-high inhibit read as high when floating, and the active-low inhibit reads as low, so a floating inhibit always shuts the bridge. Every input passes through a two-flop synchronizer, and edges are detected on the synchronized value.

Top module: `hbridge_guard`

## Requirements
- R1: When the bridge is operating (leg_x_en=1), each leg follows its own direction input with true polarity (leg_x_hi=1 drives high, 0 drives low). The four combinations (dir_a,dir_b) = (1,0), (0,1), (0,0), (1,1) give forward, reverse, both low sides on, and both high sides on. leg_x_en=0 means high impedance, and leg_x_hi then reads 0.
- R2: While inh_p is 1, both legs are at high impedance and fault_n is 0.
- R3: While inh_n is 0, both legs are at high impedance and fault_n is 0.
- R4: A short flag latches both legs to high impedance and fault_n to 0. This holds whatever the direction inputs are, and it persists after the flag drops.
- R5: A 1-to-0 transition of the synchronized inh_p clears a latched short. The bridge then follows the inputs again with fault_n=1.
- R6: A 0-to-1 transition of the synchronized inh_n clears a latched short in the same way.
- R7: An inhibit toggle clears an overtemperature latch only while cool is 1. With cool at 0 the latch holds.
- R8: Undervoltage puts both legs at high impedance and fault_n at 0 while it lasts. Normal operation returns when it drops, with no toggle.
- R9: A floating dir_a, dir_b or inh_p reads as 1. A floating inh_n reads as 0, so a floating inhibit disables the bridge.
- R10: If a clearing edge arrives while the short or overtemperature flag is still set, the fault wins and the latch stays set.
- R11: During reset and until the synchronizers have filled, both legs are at high impedance and fault_n is 0. The latch starts clear, so the bridge runs once the inputs are valid, with no toggle needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_a | input | 1 | Direction of leg A (1 = high) |
| dir_b | input | 1 | Direction of leg B (1 = high) |
| inh_p | input | 1 | Inhibit, active high |
| inh_n | input | 1 | Inhibit, active low |
| flt_a | input | 1 | dir_a pin is floating |
| flt_b | input | 1 | dir_b pin is floating |
| flt_p | input | 1 | inh_p pin is floating |
| flt_n | input | 1 | inh_n pin is floating |
| short_f | input | 1 | Hard short detected |
| hot_f | input | 1 | Overtemperature trip |
| uv_f | input | 1 | Supply undervoltage |
| cool_f | input | 1 | Temperature below trip minus hysteresis |
| leg_a_en | output | 1 | Leg A driven (0 = high impedance) |
| leg_a_hi | output | 1 | Leg A level when driven |
| leg_b_en | output | 1 | Leg B driven (0 = high impedance) |
| leg_b_hi | output | 1 | Leg B level when driven |
| fault_n | output | 1 | Fault status, active low |

## Verification
The latch can be set and cleared in the same cycle: an inhibit toggle can reach the edge detector while the short flag is still asserted. The bench holds the short flag high, lowers inh_p, and then expects the legs to stay released and fault_n to stay low. After the flag has dropped, a second toggle must restore operation. The same overlap with cool low shows that an overtemperature latch cannot be cleared early.

// File: rtl/hbridge_guard.sv
module hbridge_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_a,
  input  logic dir_b,
  input  logic inh_p,
  input  logic inh_n,
  input  logic flt_a,
  input  logic flt_b,
  input  logic flt_p,
  input  logic flt_n,
  input  logic short_f,
  input  logic hot_f,
  input  logic uv_f,
  input  logic cool_f,
  output logic leg_a_en,
  output logic leg_a_hi,
  output logic leg_b_en,
  output logic leg_b_hi,
  output logic fault_n
);
  localparam int NS = 8;
  // bit order: a, b, p, n, short, hot, uv, cool
  localparam logic [NS-1:0] SYNC_RST = 8'b1000_0100;

  logic [NS-1:0] raw, s1, s2;
  logic [1:0]    fill;
  logic          p_d, n_d;
  logic          sc_lat, ot_lat;

  // pin pull models: floating reads as its default level
  assign raw = {cool_f, uv_f, hot_f, short_f,
                flt_n ? 1'b0 : inh_n,
                flt_p ? 1'b1 : inh_p,
                flt_b ? 1'b1 : dir_b,
                flt_a ? 1'b1 : dir_a};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1   <= SYNC_RST;
      s2   <= SYNC_RST;
      fill <= 2'b00;
    end else begin
      s1   <= raw;
      s2   <= s1;
      fill <= {fill[0], 1'b1};
    end

  logic a_s, b_s, p_s, n_s, sc_s, ot_s, uv_s, cool_s, vld;
  assign {cool_s, uv_s, ot_s, sc_s, n_s, p_s, b_s, a_s} = s2;
  assign vld = fill[1];

  logic clr, disabled, latched, run;
  assign clr      = (p_d & ~p_s) | (~n_d & n_s);
  assign disabled = p_s | ~n_s;
  assign latched  = sc_lat | ot_lat;
  assign run      = vld & ~disabled & ~uv_s & ~latched;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_d    <= 1'b1;
      n_d    <= 1'b0;
      sc_lat <= 1'b0;
      ot_lat <= 1'b0;
    end else begin
      p_d    <= p_s;
      n_d    <= n_s;
      sc_lat <= sc_s | (sc_lat & ~clr);
      ot_lat <= ot_s | (ot_lat & ~(clr & cool_s));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      leg_a_en <= 1'b0;
      leg_a_hi <= 1'b0;
      leg_b_en <= 1'b0;
      leg_b_hi <= 1'b0;
      fault_n  <= 1'b0;
    end else begin
      leg_a_en <= run;
      leg_b_en <= run;
      leg_a_hi <= run & a_s;
      leg_b_hi <= run & b_s;
      fault_n  <= ~(disabled | uv_s | latched);
    end

  p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    leg_a_en |-> (leg_a_hi == $past(a_s)) && (leg_b_hi == $past(b_s)));
  p_inh_p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    p_s |=> !leg_a_en && !leg_b_en && !fault_n);
  p_inh_n_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !n_s |=> !leg_a_en && !leg_b_en && !fault_n);
  p_latch_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_lat |=> !leg_a_en && !leg_b_en && !fault_n);
  p_hot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_lat && !cool_s) |=> ot_lat);
  p_uv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |=> !leg_a_en && !fault_n);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_s && clr) |=> sc_lat);
  p_legs_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    leg_a_en == leg_b_en);
endmodule

// File: tb/hbridge_guard_tb_top.sv
module hbridge_guard_tb_top;
  logic clk = 0, rst_n = 0;
  logic dir_a = 1, dir_b = 0, inh_p = 0, inh_n = 1;
  logic flt_a = 0, flt_b = 0, flt_p = 0, flt_n = 0;
  logic short_f = 0, hot_f = 0, uv_f = 0, cool_f = 1;
  logic leg_a_en, leg_a_hi, leg_b_en, leg_b_hi, fault_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hbridge_guard dut_i (.*);

  localparam logic [4:0] FWD = 5'b11101, REV = 5'b10111,
                         BLO = 5'b10101, BHI = 5'b11111, OFF = 5'b00000;

  task automatic check(string tag, logic [4:0] exp);
    logic [4:0] act;
    act = {leg_a_en, leg_a_hi, leg_b_en, leg_b_hi, fault_n};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic toggle_p();
    inh_p = 1; settle(); inh_p = 0; settle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 in reset", OFF);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    check("R11 before sync fill", OFF);
    settle();
    check("R11 runs without toggle", FWD);
  endtask

  task automatic t_truth();
    dir_a = 1; dir_b = 0; settle(); check("R1 forward", FWD);
    dir_a = 0; dir_b = 1; settle(); check("R1 reverse", REV);
    dir_a = 0; dir_b = 0; settle(); check("R1 brake low", BLO);
    dir_a = 1; dir_b = 1; settle(); check("R1 brake high", BHI);
  endtask

  task automatic t_inhibit();
    inh_p = 1; settle(); check("R2 inh_p high", OFF);
    inh_p = 0; settle(); check("R2 release", BHI);
    inh_n = 0; settle(); check("R3 inh_n low", OFF);
    inh_n = 1; settle(); check("R3 release", BHI);
  endtask

  task automatic t_short();
    dir_a = 1; dir_b = 0;
    short_f = 1; repeat (3) @(negedge clk); short_f = 0;
    settle(); check("R4 latched", OFF);
    dir_a = 0; dir_b = 1; settle(); check("R4 ignores dirs", OFF);
    toggle_p(); check("R5 clear by inh_p fall", REV);
    short_f = 1; repeat (3) @(negedge clk); short_f = 0;
    settle(); check("R4 relatch", OFF);
    inh_n = 0; settle(); inh_n = 1; settle();
    check("R6 clear by inh_n rise", REV);
  endtask

  task automatic t_hot();
    dir_a = 1; dir_b = 0;
    cool_f = 0;
    hot_f = 1; repeat (3) @(negedge clk); hot_f = 0;
    settle(); check("R7 hot latched", OFF);
    toggle_p(); check("R7 hold while warm", OFF);
    cool_f = 1; settle();
    toggle_p(); check("R7 clear when cool", FWD);
  endtask

  task automatic t_uv();
    uv_f = 1; settle(); check("R8 undervoltage off", OFF);
    uv_f = 0; settle(); check("R8 auto recovery", FWD);
  endtask

  task automatic t_float();
    dir_a = 0; dir_b = 0; flt_a = 1; settle();
    check("R9 floating dir_a high", FWD);
    flt_a = 0; flt_b = 1; settle();
    check("R9 floating dir_b high", REV);
    flt_b = 0; flt_p = 1; settle();
    check("R9 floating inh_p disables", OFF);
    flt_p = 0; settle(); flt_n = 1; settle();
    check("R9 floating inh_n disables", OFF);
    flt_n = 0; settle();
    check("R9 floats removed", BLO);
  endtask

  task automatic t_overlap();
    dir_a = 1; dir_b = 0;
    short_f = 1; settle();
    toggle_p(); check("R10 edge during short", OFF);
    short_f = 0; settle(); check("R10 latch kept after flag", OFF);
    toggle_p(); check("R10 later clear", FWD);
    cool_f = 0; hot_f = 1; settle();
    inh_n = 0; settle(); inh_n = 1; settle();
    hot_f = 0; cool_f = 1; settle();
    check("R10 hot overlap kept", OFF);
    toggle_p(); check("R10 hot later clear", FWD);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_truth();
    t_inhibit();
    t_short();
    t_hot();
    t_uv();
    t_float();
    t_overlap();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule